// File: doc/BRIEF.md
# Multiplexed PDM Microphone Capture Front-End

This block drives one shared pulse-density clock to a large bank of digital microphones wired two per data line, where one microphone of each pair drives the line while the clock is high and the other while it is low. The system clock is divided to make that clock. Every data line goes through a two-flop synchronizer and is sampled once in each half of the clock period, a fixed number of system cycles after the clock edge. The delay leaves room for the microphones' output delay. Each clock period therefore yields two bits per line.

Once per period the two half-period captures are packed into one frame of fixed length and sent on a word-wide valid/ready stream. The first word is a header that carries a rolling sequence number. The captured bits follow it, and start-of-frame and end-of-frame marks flag the first and last words. Back-pressure follows the usual valid/ready rules. Once valid is raised it stays high, and data and the marks stay unchanged until ready is seen. A word moves on every cycle in which valid and ready are both high.

The block holds one frame at a time. A downstream stall can keep a frame from draining before the next capture is ready. In that case the new capture is discarded whole, and its sequence number is still used up, so the receiver sees the loss as a gap.

Top module: `pdm_mic_capture`

## Requirements
- R1: `pdm_clk_o` is low during reset. On the first system cycle after reset it goes high. It then repeats with period DIV: high for DIV/2 cycles, low for DIV/2 cycles.
- R2: A line's clock-high bit is the value that line had at the system clock edge CAP_DELAY-1 cycles after the edge that raised `pdm_clk_o`.
- R3: A line's clock-low bit is the value that line had at the system clock edge CAP_DELAY-1 cycles after the edge that lowered `pdm_clk_o`.
- R4: A frame has 2*N_PINS/WORD_W+1 words. Word 0 is the header. Words 1 to N_PINS/WORD_W hold the clock-high bits, and the remaining words hold the clock-low bits. Line i's clock-high bit is bit i mod WORD_W of word 1+i/WORD_W. Its clock-low bit is bit i mod WORD_W of word 1+N_PINS/WORD_W+i/WORD_W.
- R5: The header is a SEQ_W-bit counter, zero-extended to WORD_W bits. It is 0 for the first capture after reset and rises by one for each capture, whether the capture is sent or dropped. It wraps from all ones to 0.
- R6: `out_sof_o` is high only with word 0 of a frame, and `out_eof_o` only with the last word. Both are low while `out_valid_o` is low.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the next cycle keeps `out_valid_o` high, and `out_data_o`, `out_sof_o` and `out_eof_o` are unchanged.
- R8: A frame that is sent becomes valid in the system cycle that follows the clock-low capture edge. It then advances one word per cycle in which ready is high.
- R9: A capture is sent only if no frame is pending when the capture is complete. A frame whose last word is accepted in that same cycle does not count as pending. Otherwise the capture is discarded whole.
- R10: During reset `out_valid_o`, `out_sof_o` and `out_eof_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_clk_o | output | 1 | Shared microphone clock, system clock divided by DIV |
| mic_data_i | input | N_PINS | Microphone data lines, two microphones per line |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream ready to take a word |
| out_data_o | output | WORD_W | Output word |
| out_sof_o | output | 1 | Marks the header word of a frame |
| out_eof_o | output | 1 | Marks the last word of a frame |

## Verification
The bench uses N_PINS=64, DIV=8, CAP_DELAY=2 and SEQ_W=4. With these values a five-word frame must fit inside an eight-cycle clock period, so the whole frame layout is visible at every word. The 4-bit sequence counter wraps every sixteen captures, so the wrap to 0 occurs many times in a short run. Ready is held low in bursts of twenty cycles, which is longer than a period, so the drop path and the resulting sequence gaps are exercised. The lines are driven all-zero, all-one, as a walking one, and with random values. Together these show each line's position and each edge's sampling point.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

  // Words in one frame: header plus both half-period captures.
  function automatic int unsigned frame_words(int unsigned n_pins, int unsigned word_w);
    return (2 * n_pins) / word_w + 1;
  endfunction

  // Index width able to address n items (at least one bit).
  function automatic int unsigned idx_w(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pdm_cap_clkgen.sv
module pdm_cap_clkgen #(
  parameter int DIV       = 16,
  parameter int CAP_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic pdm_clk,
  output logic rise_smp,
  output logic fall_smp
);
  localparam int CNT_W = pdm_cap_pkg::idx_w(DIV);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DIV / 2);
  localparam logic [CNT_W-1:0] RISE_C = CNT_W'(CAP_DELAY);
  localparam logic [CNT_W-1:0] FALL_C = CNT_W'(DIV / 2 + CAP_DELAY);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             pdm_q;

  always_comb begin
    cnt_nxt = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
  end

  // Counter idles at the last phase so the first cycle after reset is a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LAST_C;
      pdm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      pdm_q <= (cnt_nxt < HALF_C);
    end
  end

  assign pdm_clk  = pdm_q;
  assign rise_smp = (cnt_q == RISE_C);
  assign fall_smp = (cnt_q == FALL_C);

  // R1
  pdm_high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> pdm_q);

  // R1
  pdm_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == HALF_C) |-> !pdm_q);

endmodule

// File: rtl/pdm_cap_sampler.sv
module pdm_cap_sampler #(
  parameter int N_PINS = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins,
  input  logic              rise_smp,
  input  logic              fall_smp,
  output logic [N_PINS-1:0] rise_bits,
  output logic [N_PINS-1:0] fall_bits,
  output logic              cap_done
);
  logic [N_PINS-1:0] synced;
  logic [N_PINS-1:0] rise_q;
  logic [N_PINS-1:0] fall_q;
  logic              done_q;

  for (genvar p = 0; p < N_PINS; p++) begin : g_sync
    logic [1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[0], pins[p]};
    end
    assign synced[p] = chain_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (rise_smp) rise_q <= synced;
      if (fall_smp) fall_q <= synced;
      done_q <= fall_smp;
    end
  end

  assign rise_bits = rise_q;
  assign fall_bits = fall_q;
  assign cap_done  = done_q;

  // R2
  rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_smp |=> $stable(rise_q));

  // R3
  fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_smp |=> $stable(fall_q));

endmodule

// File: rtl/pdm_cap_framer.sv
module pdm_cap_framer #(
  parameter int N_PINS      = 96,
  parameter int WORD_W      = 32,
  parameter int SEQ_W       = 32,
  parameter int FRAME_WORDS = pdm_cap_pkg::frame_words(N_PINS, WORD_W)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_done,
  input  logic [N_PINS-1:0]             rise_bits,
  input  logic [N_PINS-1:0]             fall_bits,
  input  logic                          can_take,
  output logic                          load,
  output logic [FRAME_WORDS*WORD_W-1:0] frame_flat
);
  logic [SEQ_W-1:0] seq_q;

  // Sequence advances on every completed capture, sent or dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seq_q <= '0;
    else if (cap_done) seq_q <= seq_q + 1'b1;
  end

  assign load       = cap_done && can_take;
  assign frame_flat = {fall_bits, rise_bits, WORD_W'(seq_q)};

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> (seq_q == $past(seq_q) + 1'b1));

  // R5
  seq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_done |=> $stable(seq_q));

endmodule

// File: rtl/pdm_cap_serializer.sv
module pdm_cap_serializer #(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [FRAME_WORDS*WORD_W-1:0] frame_flat,
  output logic                          can_take,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [WORD_W-1:0]             out_data,
  output logic                          out_sof,
  output logic                          out_eof
);
  localparam int IDX_W = pdm_cap_pkg::idx_w(FRAME_WORDS);
  localparam logic [IDX_W-1:0] LAST_C = IDX_W'(FRAME_WORDS - 1);

  logic [WORD_W-1:0] buf_q [FRAME_WORDS];
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q;
  logic              fire;
  logic              at_last;

  assign fire     = busy_q && out_ready;
  assign at_last  = (idx_q == LAST_C);
  assign can_take = !busy_q || (fire && at_last);

  for (genvar w = 0; w < FRAME_WORDS; w++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    buf_q[w] <= '0;
      else if (load) buf_q[w] <= frame_flat[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (fire) begin
      if (at_last) busy_q <= 1'b0;
      else         idx_q  <= idx_q + 1'b1;
    end
  end

  assign out_valid = busy_q;
  assign out_data  = buf_q[idx_q];
  assign out_sof   = busy_q && (idx_q == '0);
  assign out_eof   = busy_q && at_last;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sof) && $stable(out_eof)));

  // R6
  marks_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> !out_eof);

  // R8
  launch_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_valid && out_sof));

  // R9
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |-> !load);

endmodule

// File: rtl/pdm_mic_capture.sv
module pdm_mic_capture #(
  parameter int N_PINS    = 96,
  parameter int DIV       = 16,
  parameter int CAP_DELAY = 2,
  parameter int WORD_W    = 32,
  parameter int SEQ_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              pdm_clk_o,
  input  logic [N_PINS-1:0] mic_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o
);
  localparam int FRAME_WORDS = pdm_cap_pkg::frame_words(N_PINS, WORD_W);

  logic                          rise_smp;
  logic                          fall_smp;
  logic [N_PINS-1:0]             rise_bits;
  logic [N_PINS-1:0]             fall_bits;
  logic                          cap_done;
  logic                          can_take;
  logic                          load;
  logic [FRAME_WORDS*WORD_W-1:0] frame_flat;

  pdm_cap_clkgen #(.DIV(DIV), .CAP_DELAY(CAP_DELAY)) clkgen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdm_clk  (pdm_clk_o),
    .rise_smp (rise_smp),
    .fall_smp (fall_smp)
  );

  pdm_cap_sampler #(.N_PINS(N_PINS)) sampler_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins      (mic_data_i),
    .rise_smp  (rise_smp),
    .fall_smp  (fall_smp),
    .rise_bits (rise_bits),
    .fall_bits (fall_bits),
    .cap_done  (cap_done)
  );

  pdm_cap_framer #(
    .N_PINS(N_PINS), .WORD_W(WORD_W), .SEQ_W(SEQ_W), .FRAME_WORDS(FRAME_WORDS)
  ) framer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_done   (cap_done),
    .rise_bits  (rise_bits),
    .fall_bits  (fall_bits),
    .can_take   (can_take),
    .load       (load),
    .frame_flat (frame_flat)
  );

  pdm_cap_serializer #(.WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS)) ser_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .frame_flat (frame_flat),
    .can_take   (can_take),
    .out_valid  (out_valid_o),
    .out_ready  (out_ready_i),
    .out_data   (out_data_o),
    .out_sof    (out_sof_o),
    .out_eof    (out_eof_o)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid_o && !out_sof_o && !out_eof_o));

endmodule

// File: tb/pdm_mic_capture_tb.sv
module pdm_mic_capture_tb_top;
  localparam int N    = 64;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int CAPD = 2;
  localparam int WW   = 32;
  localparam int SQW  = 4;
  localparam int NW   = N / WW;
  localparam int FW   = 2 * NW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins_drv = '0;
  logic          rdy_drv = 1'b1;
  logic          pdm_clk_o;
  logic          out_valid_o;
  logic [WW-1:0] out_data_o;
  logic          out_sof_o;
  logic          out_eof_o;

  always #5 clk = ~clk;

  pdm_mic_capture #(.N_PINS(N), .DIV(DIV), .CAP_DELAY(CAPD), .WORD_W(WW), .SEQ_W(SQW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pdm_clk_o(pdm_clk_o), .mic_data_i(pins_drv),
    .out_valid_o(out_valid_o), .out_ready_i(rdy_drv), .out_data_o(out_data_o),
    .out_sof_o(out_sof_o), .out_eof_o(out_eof_o)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising clock edge.
  logic [N-1:0]  hist [$];
  logic [WW-1:0] fq   [$];
  int            mcnt = DIV - 1;
  logic [N-1:0]  m_rise = '0;
  logic [N-1:0]  m_fall = '0;
  bit            pend = 0;
  int            mseq = 0;
  int            mdrops = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); fq.delete();
      mcnt = DIV - 1; pend = 0; mseq = 0;
      m_rise = '0; m_fall = '0;
    end else begin
      logic [N-1:0] cap;
      bit hs;
      hs  = (fq.size() > 0) && rdy_drv;
      cap = (hist.size() >= 2) ? hist[hist.size()-2] : '0;
      if (hs) void'(fq.pop_front());
      if (pend) begin
        if (fq.size() == 0) begin
          fq.push_back(WW'(mseq));
          for (int k = 0; k < NW; k++) fq.push_back(m_rise[k*WW +: WW]);
          for (int k = 0; k < NW; k++) fq.push_back(m_fall[k*WW +: WW]);
        end else mdrops++;
        mseq = (mseq + 1) % (1 << SQW);
      end
      pend = (mcnt == HALF + CAPD);
      if (mcnt == CAPD)        m_rise = cap;
      if (mcnt == HALF + CAPD) m_fall = cap;
      hist.push_back(pins_drv);
      if (hist.size() > 4) void'(hist.pop_front());
      mcnt = (mcnt + 1) % DIV;
    end
  end

  int prev_hdr = -1;
  int gap_seen = 0;
  int wrap_seen = 0;
  int frames = 0;

  task automatic compare();
    int widx;
    string tag;
    chk(pdm_clk_o == (mcnt < HALF), "R1 pdm clock", 64'(pdm_clk_o), 64'(mcnt < HALF));
    chk(out_valid_o == (fq.size() > 0), "R7 R8 valid", 64'(out_valid_o), 64'(fq.size() > 0));
    if (out_valid_o && fq.size() > 0) begin
      widx = FW - fq.size();
      if (widx == 0)       tag = "R5 header word";
      else if (widx <= NW) tag = "R2 R4 high-phase word";
      else                 tag = "R3 R4 low-phase word";
      chk(out_data_o == fq[0], tag, 64'(out_data_o), 64'(fq[0]));
      chk(out_sof_o == (widx == 0), "R6 sof", 64'(out_sof_o), 64'(widx == 0));
      chk(out_eof_o == (fq.size() == 1), "R6 eof", 64'(out_eof_o), 64'(fq.size() == 1));
    end else begin
      chk(!out_sof_o && !out_eof_o, "R6 marks idle", {62'b0, out_sof_o, out_eof_o}, 64'b0);
    end
    if (out_valid_o && out_sof_o && rdy_drv) begin
      frames++;
      if (prev_hdr >= 0) begin
        if (out_data_o == 0 && prev_hdr == (1 << SQW) - 1) wrap_seen++;
        if (int'(out_data_o) != (prev_hdr + 1) % (1 << SQW)) gap_seen++;
      end
      prev_hdr = int'(out_data_o);
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R10 reset state
      chk(!out_valid_o && !out_sof_o && !out_eof_o, "R10 reset outputs",
          {61'b0, out_valid_o, out_sof_o, out_eof_o}, 64'b0);
      chk(pdm_clk_o == 1'b0, "R1 reset clock", 64'(pdm_clk_o), 64'b0);
    end
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 2400; cyc++) begin
      @(negedge clk);
      compare();
      if (cyc < 200)       begin pins_drv = '0; rdy_drv = 1'b1; end
      else if (cyc < 400)  begin pins_drv = '1; rdy_drv = 1'b1; end
      else if (cyc < 800)  begin pins_drv = '0; pins_drv[(cyc / 3) % N] = 1'b1; rdy_drv = 1'b1; end
      else if (cyc < 1400) begin pins_drv = {$urandom, $urandom}; rdy_drv = $urandom_range(0, 1) == 1; end
      else if (cyc < 2000) begin pins_drv = {$urandom, $urandom}; rdy_drv = (cyc % 40) >= 20; end
      else                 begin pins_drv = {$urandom, $urandom}; rdy_drv = 1'b1; end
    end
    // R9: long stalls must have produced drops visible as header gaps
    chk(gap_seen > 0 && mdrops > 0, "R9 drop gap seen", 64'(gap_seen), 64'(mdrops));
    // R5: wrap from all ones to zero observed on the stream
    chk(wrap_seen > 0, "R5 header wrap", 64'(wrap_seen), 64'd1);
    chk(frames > 100, "R8 frames delivered", 64'(frames), 64'd100);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule